// File: doc/BRIEF.md
# Prefix-Swapping Real-to-Absolute Address Mapper

This block sits between a processor's real-address stage and main storage. Every real address it receives is turned into an absolute address. The lowest 8 KB of storage and an 8 KB window at the processor's own prefix are exchanged, and every other address passes through unchanged. This lets each processor in a multiprocessor keep a private low-storage area while software still addresses it at zero.

In the same registered step, the block maintains a small array of per-4 KB-page storage keys. An access that lands inside the configured storage size marks its page as referenced if it may read, and as changed if it may write. An access that lands beyond the storage size is flagged for an addressing exception instead. A software port reads and writes whole keys, and it overrides the automatic marking when both target the same page in the same cycle. The prefix itself is held in an 8 KB-aligned register inside the block.

Top module: `prefix_abs_mapper`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_range_err` and `key_upd_valid` are 0, `prefix_o` is 0, and every key reads back as 0.
- R2: A prefix write stores `pfx_wdata` with its low 13 bits cleared, and the new value appears on `prefix_o` one cycle later.
- R3: A real address below 0x2000 maps to that address plus the current prefix.
- R4: A real address that is at least 0x2000 and lies in the range from the prefix up to (not including) prefix + 0x2000 maps to that address minus the prefix.
- R5: Every other real address maps to itself.
- R6: A request accepted at a clock edge presents its absolute address on `rsp_abs` with `rsp_valid` high in the following cycle. `rsp_valid` is low one cycle after a cycle without a request.
- R7: `rsp_range_err` is 1 exactly when the absolute address of a valid request is strictly greater than `mem_limit`. An address equal to the limit is not an error.
- R8: A key update happens only when the absolute address is not above `mem_limit`, its bits above the key index are zero, and at least one of `req_rd` or `req_wr` is set. The key index is absolute address bits [17:12] with the default 64 pages. The update sets bit 1 (referenced) if `req_rd` is set and bit 0 (changed) if `req_wr` is set, and keeps all other key bits. The written index and value appear on `key_upd_idx`/`key_upd_data` with `key_upd_valid` in the response cycle.
- R9: A request that does not qualify for an update (range error, page beyond the array, or neither permission) leaves every key unchanged and keeps `key_upd_valid` low.
- R10: A software key write stores `key_sw_wdata` at `key_sw_idx`. `key_sw_rdata` returns the key at `key_sw_idx` combinationally. When a software write and an automatic update target the same index in one cycle, the software value is stored and `key_upd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_addr | input | AW | Real address |
| req_rd | input | 1 | Access permission includes read |
| req_wr | input | 1 | Access permission includes write |
| mem_limit | input | AW | Highest valid absolute address |
| pfx_we | input | 1 | Prefix register write enable |
| pfx_wdata | input | AW | New prefix value (low 13 bits ignored) |
| prefix_o | output | AW | Current prefix |
| key_sw_we | input | 1 | Software key write enable |
| key_sw_idx | input | IW | Software key index |
| key_sw_wdata | input | KW | Software key write data |
| key_sw_rdata | output | KW | Key at `key_sw_idx` |
| rsp_valid | output | 1 | Response present |
| rsp_abs | output | AW | Absolute address |
| rsp_range_err | output | 1 | Addressing exception: address above limit |
| key_upd_valid | output | 1 | Automatic key write performed |
| key_upd_idx | output | IW | Page index of the key write |
| key_upd_data | output | KW | Key value written |

## Verification
A wrong prefix register shows up on `prefix_o` one cycle after the write. It also distorts every low-area and prefix-area response after that, so random traffic biased toward both windows exposes it within a few requests. A corrupted key entry is invisible until that page is touched again or read back through the software port. For that reason the bench models every key and compares `key_upd_data`, which carries the merged old value, on every update, and it reads keys back directly after the same-index collision and the non-qualifying cases. Range-limit errors appear on the very response of the offending request, and the bench probes the address exactly at the limit as well as the one just above it.

// File: rtl/amap_pkg.sv
package amap_pkg;
    localparam int SWAP_BITS = 13;   // 8 KB swapped window
    localparam int PAGE_BITS = 12;   // 4 KB key granule
    localparam int REF_POS   = 1;
    localparam int CHG_POS   = 0;

    typedef enum logic [1:0] {
        MAP_LOW  = 2'd0,
        MAP_PFX  = 2'd1,
        MAP_PASS = 2'd2
    } map_kind_e;
endpackage

// File: rtl/amap_swap.sv
module amap_swap
    import amap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] raddr,
    input  logic [AW-1:0] prefix,
    output logic [AW-1:0] abs_addr,
    output map_kind_e     kind
);
    localparam int HI_W = AW - SWAP_BITS;

    logic [HI_W-1:0] r_hi;
    logic [HI_W-1:0] p_hi;

    always_comb begin
        r_hi = raddr[AW-1:SWAP_BITS];
        p_hi = prefix[AW-1:SWAP_BITS];
        if (r_hi == '0) begin
            kind     = MAP_LOW;
            abs_addr = raddr + prefix;
        end else if (r_hi == p_hi) begin
            kind     = MAP_PFX;
            abs_addr = raddr - prefix;
        end else begin
            kind     = MAP_PASS;
            abs_addr = raddr;
        end
    end
endmodule

// File: rtl/amap_keycalc.sv
module amap_keycalc
    import amap_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PAGES = 64,
    parameter int KW    = 7
) (
    input  logic                     valid,
    input  logic [AW-1:0]            abs_addr,
    input  logic [AW-1:0]            mem_limit,
    input  logic                     rd,
    input  logic                     wr,
    input  logic [KW-1:0]            old_key,
    output logic [$clog2(PAGES)-1:0] idx,
    output logic                     range_err,
    output logic                     upd_en,
    output logic [KW-1:0]            new_key
);
    localparam int IW  = $clog2(PAGES);
    localparam int TOP = PAGE_BITS + IW;

    logic in_array;

    always_comb begin
        idx       = abs_addr[TOP-1:PAGE_BITS];
        in_array  = (abs_addr[AW-1:TOP] == '0);
        range_err = valid && (abs_addr > mem_limit);
        upd_en    = valid && !range_err && in_array && (rd || wr);
        new_key   = old_key;
        if (rd) new_key[REF_POS] = 1'b1;
        if (wr) new_key[CHG_POS] = 1'b1;
    end
endmodule

// File: rtl/amap_keyfile.sv
module amap_keyfile #(
    parameter int PAGES = 64,
    parameter int KW    = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(PAGES)-1:0] auto_idx,
    output logic [KW-1:0]            auto_rdata,
    input  logic                     auto_we,
    input  logic [KW-1:0]            auto_wdata,
    input  logic [$clog2(PAGES)-1:0] sw_idx,
    output logic [KW-1:0]            sw_rdata,
    input  logic                     sw_we,
    input  logic [KW-1:0]            sw_wdata
);
    localparam int IW = $clog2(PAGES);

    logic [KW-1:0] keys_q [PAGES];
    logic [KW-1:0] keys_d [PAGES];

    assign auto_rdata = keys_q[auto_idx];
    assign sw_rdata   = keys_q[sw_idx];

    always_comb begin
        for (int i = 0; i < PAGES; i++) begin
            keys_d[i] = keys_q[i];
            if (sw_we && sw_idx == IW'(i)) begin
                keys_d[i] = sw_wdata;
            end else if (auto_we && auto_idx == IW'(i)) begin
                keys_d[i] = auto_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGES; i++) begin
            if (!rst_n) keys_q[i] <= '0;
            else        keys_q[i] <= keys_d[i];
        end
    end
endmodule

// File: rtl/prefix_abs_mapper.sv
module prefix_abs_mapper
    import amap_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PAGES = 64,
    parameter int KW    = 7,
    localparam int IW   = $clog2(PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_rd,
    input  logic          req_wr,
    input  logic [AW-1:0] mem_limit,
    input  logic          pfx_we,
    input  logic [AW-1:0] pfx_wdata,
    output logic [AW-1:0] prefix_o,
    input  logic          key_sw_we,
    input  logic [IW-1:0] key_sw_idx,
    input  logic [KW-1:0] key_sw_wdata,
    output logic [KW-1:0] key_sw_rdata,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_abs,
    output logic          rsp_range_err,
    output logic          key_upd_valid,
    output logic [IW-1:0] key_upd_idx,
    output logic [KW-1:0] key_upd_data
);
    typedef struct packed {
        logic [AW-1:0] prefix;
        logic          valid;
        logic [AW-1:0] abs_addr;
        logic          err;
        logic          kv;
        logic [IW-1:0] kidx;
        logic [KW-1:0] kdata;
    } state_t;

    state_t st_d, st_q;

    logic [AW-1:0] map_abs;
    map_kind_e     map_kind;
    logic [IW-1:0] calc_idx;
    logic          calc_err;
    logic          calc_upd;
    logic [KW-1:0] calc_key;
    logic [KW-1:0] old_key;
    logic          auto_commit;

    amap_swap #(.AW(AW)) u_swap (
        .raddr    (req_addr),
        .prefix   (st_q.prefix),
        .abs_addr (map_abs),
        .kind     (map_kind)
    );

    amap_keycalc #(.AW(AW), .PAGES(PAGES), .KW(KW)) u_calc (
        .valid     (req_valid),
        .abs_addr  (map_abs),
        .mem_limit (mem_limit),
        .rd        (req_rd),
        .wr        (req_wr),
        .old_key   (old_key),
        .idx       (calc_idx),
        .range_err (calc_err),
        .upd_en    (calc_upd),
        .new_key   (calc_key)
    );

    // Software write to the same page wins over the automatic marking.
    assign auto_commit = calc_upd && !(key_sw_we && key_sw_idx == calc_idx);

    amap_keyfile #(.PAGES(PAGES), .KW(KW)) u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_idx   (calc_idx),
        .auto_rdata (old_key),
        .auto_we    (auto_commit),
        .auto_wdata (calc_key),
        .sw_idx     (key_sw_idx),
        .sw_rdata   (key_sw_rdata),
        .sw_we      (key_sw_we),
        .sw_wdata   (key_sw_wdata)
    );

    always_comb begin
        st_d          = st_q;
        st_d.valid    = req_valid;
        st_d.abs_addr = map_abs;
        st_d.err      = calc_err;
        st_d.kv       = auto_commit;
        st_d.kidx     = calc_idx;
        st_d.kdata    = calc_key;
        if (pfx_we) begin
            st_d.prefix = {pfx_wdata[AW-1:SWAP_BITS], {SWAP_BITS{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prefix_o      = st_q.prefix;
    assign rsp_valid     = st_q.valid;
    assign rsp_abs       = st_q.abs_addr;
    assign rsp_range_err = st_q.err;
    assign key_upd_valid = st_q.kv;
    assign key_upd_idx   = st_q.kidx;
    assign key_upd_data  = st_q.kdata;
endmodule

// File: rtl/prefix_abs_mapper_chk.sv
module prefix_abs_mapper_chk
    import amap_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PAGES = 64,
    parameter int KW    = 7,
    localparam int IW   = $clog2(PAGES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          req_rd,
    input logic [AW-1:0] mem_limit,
    input logic          pfx_we,
    input logic [AW-1:0] pfx_wdata,
    input logic [AW-1:0] prefix_o,
    input logic          rsp_valid,
    input logic [AW-1:0] rsp_abs,
    input logic          rsp_range_err,
    input logic          key_upd_valid,
    input logic [KW-1:0] key_upd_data
);
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_prefix_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_we |=> prefix_o == {$past(pfx_wdata[AW-1:SWAP_BITS]), {SWAP_BITS{1'b0}}});

    assert_low_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[AW-1:SWAP_BITS] == '0)
            |=> rsp_abs == $past(req_addr) + $past(prefix_o));

    assert_limit_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_abs <= $past(mem_limit)) |-> !rsp_range_err);

    assert_err_no_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_range_err |-> !key_upd_valid);

    assert_upd_with_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        key_upd_valid |-> rsp_valid);

    assert_ref_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (key_upd_valid && $past(req_rd)) |-> key_upd_data[REF_POS]);
endmodule

bind prefix_abs_mapper prefix_abs_mapper_chk #(.AW(AW), .PAGES(PAGES), .KW(KW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_rd        (req_rd),
    .mem_limit     (mem_limit),
    .pfx_we        (pfx_we),
    .pfx_wdata     (pfx_wdata),
    .prefix_o      (prefix_o),
    .rsp_valid     (rsp_valid),
    .rsp_abs       (rsp_abs),
    .rsp_range_err (rsp_range_err),
    .key_upd_valid (key_upd_valid),
    .key_upd_data  (key_upd_data)
);

// File: tb/tb_prefix_abs_mapper.sv
module tb_prefix_abs_mapper;
    localparam int AW     = 32;
    localparam int PAGES  = 64;
    localparam int KW     = 7;
    localparam int IW     = $clog2(PAGES);
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_rd = 1'b0;
    logic          req_wr = 1'b0;
    logic [AW-1:0] mem_limit = 32'h0003_FFFF;
    logic          pfx_we = 1'b0;
    logic [AW-1:0] pfx_wdata = '0;
    logic [AW-1:0] prefix_o;
    logic          key_sw_we = 1'b0;
    logic [IW-1:0] key_sw_idx = '0;
    logic [KW-1:0] key_sw_wdata = '0;
    logic [KW-1:0] key_sw_rdata;
    logic          rsp_valid;
    logic [AW-1:0] rsp_abs;
    logic          rsp_range_err;
    logic          key_upd_valid;
    logic [IW-1:0] key_upd_idx;
    logic [KW-1:0] key_upd_data;

    always #(CLK_NS/2) clk = ~clk;

    prefix_abs_mapper #(.AW(AW), .PAGES(PAGES), .KW(KW)) dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [AW-1:0] m_pfx;
    logic [KW-1:0] m_keys [PAGES];

    function automatic logic [AW-1:0] ref_abs(input logic [AW-1:0] a, input logic [AW-1:0] p);
        if (a < 32'h2000) return a + p;
        if (a >= p && a < p + 32'h2000) return a - p;
        return a;
    endfunction

    task automatic chk(input string req, input string what, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One request cycle: drive at negedge, compare after the next posedge.
    task automatic step(input string tag, input logic v, input logic [AW-1:0] a,
                        input logic rd, input logic wr, input logic pw,
                        input logic [AW-1:0] pd, input logic sw,
                        input logic [IW-1:0] si, input logic [KW-1:0] sd);
        logic [AW-1:0] e_abs;
        logic          e_err, e_upd;
        logic [IW-1:0] e_idx;
        logic [KW-1:0] e_key;
        @(negedge clk);
        req_valid = v; req_addr = a; req_rd = rd; req_wr = wr;
        pfx_we = pw; pfx_wdata = pd;
        key_sw_we = sw; key_sw_idx = si; key_sw_wdata = sd;
        e_abs = ref_abs(a, m_pfx);
        e_err = v && (e_abs > mem_limit);
        e_idx = e_abs[PAGES_TOP()-1:12];
        e_upd = v && !e_err && (e_abs >> PAGES_TOP()) == 0 && (rd || wr);
        e_key = m_keys[e_idx] | (rd ? KW'(2) : KW'(0)) | (wr ? KW'(1) : KW'(0));
        if (sw && si == e_idx) e_upd = 1'b0;
        @(posedge clk);
        #1;
        chk("R6", "rsp_valid", AW'(rsp_valid), AW'(v));
        if (v) begin
            chk(tag, "rsp_abs", rsp_abs, e_abs);
            chk("R7", "rsp_range_err", AW'(rsp_range_err), AW'(e_err));
        end
        chk(e_upd ? "R8" : "R9", "key_upd_valid", AW'(key_upd_valid), AW'(e_upd));
        if (e_upd) begin
            chk("R8", "key_upd_idx", AW'(key_upd_idx), AW'(e_idx));
            chk("R8", "key_upd_data", AW'(key_upd_data), AW'(e_key));
            m_keys[e_idx] = e_key;
        end
        if (sw) m_keys[si] = sd;
        if (pw) begin
            m_pfx = {pd[AW-1:13], 13'b0};
            chk("R2", "prefix_o", prefix_o, m_pfx);
        end
        @(negedge clk);
        req_valid = 1'b0; pfx_we = 1'b0; key_sw_we = 1'b0;
    endtask

    function automatic int PAGES_TOP();
        return 12 + IW;
    endfunction

    task automatic req(input string tag, input logic [AW-1:0] a, input logic rd, input logic wr);
        step(tag, 1'b1, a, rd, wr, 1'b0, '0, 1'b0, '0, '0);
    endtask

    task automatic readkey(input string tag, input logic [IW-1:0] i);
        @(negedge clk);
        key_sw_idx = i;
        #1;
        chk(tag, "key_sw_rdata", AW'(key_sw_rdata), AW'(m_keys[i]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        int sel;
        void'($urandom(32'h5EED_0042));
        m_pfx = '0;
        for (int i = 0; i < PAGES; i++) m_keys[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "rsp_valid", AW'(rsp_valid), '0);
        chk("R1", "rsp_range_err", AW'(rsp_range_err), '0);
        chk("R1", "key_upd_valid", AW'(key_upd_valid), '0);
        chk("R1", "prefix_o", prefix_o, '0);
        @(negedge clk);
        rst_n = 1'b1;
        readkey("R1", 6'd0);
        readkey("R1", 6'd63);

        // R2: alignment of a prefix write
        step("R2", 1'b0, '0, 1'b0, 1'b0, 1'b1, 32'h0002_B5FF, 1'b0, '0, '0);
        // R3 / R4 / R5 directed cases
        req("R3", 32'h0000_0010, 1'b1, 1'b0);
        req("R3", 32'h0000_1FFF, 1'b0, 1'b1);
        req("R4", 32'h0002_A000, 1'b1, 1'b0);
        req("R4", 32'h0002_BFF8, 1'b0, 1'b1);
        req("R5", 32'h0002_C000, 1'b1, 1'b1);
        req("R5", 32'h0000_2000, 1'b1, 1'b0);
        readkey("R8", 6'h2A);
        readkey("R8", 6'h01);
        // R9: no permission leaves the key alone
        req("R9", 32'h0000_5000, 1'b0, 1'b0);
        readkey("R9", 6'h05);
        // R7: boundary at the limit
        mem_limit = 32'h0002_A00F;
        req("R7", 32'h0000_000F, 1'b0, 1'b1);
        req("R7", 32'h0000_0010, 1'b1, 1'b1);
        req("R7", 32'h0003_0000, 1'b1, 1'b0);
        readkey("R9", 6'h30);
        // R9: page outside the key array, but within the limit
        mem_limit = 32'hFFFF_FFFF;
        req("R9", 32'h0010_0000, 1'b1, 1'b1);
        // R10: software write collides with automatic update
        step("R10", 1'b1, 32'h0000_7000, 1'b1, 1'b1, 1'b0, '0, 1'b1, 6'h07, 7'h50);
        readkey("R10", 6'h07);
        step("R10", 1'b1, 32'h0000_8000, 1'b1, 1'b0, 1'b0, '0, 1'b1, 6'h09, 7'h33);
        readkey("R10", 6'h09);
        readkey("R10", 6'h08);
        // prefix at zero: low area maps to itself
        step("R2", 1'b0, '0, 1'b0, 1'b0, 1'b1, 32'h0000_0FFF, 1'b0, '0, '0);
        req("R3", 32'h0000_1234, 1'b1, 1'b0);

        // constrained random traffic
        mem_limit = 32'h0003_FFFF;
        for (int n = 0; n < 600; n++) begin
            sel = $urandom_range(0, 9);
            if (sel < 3)      a = AW'($urandom_range(0, 32'h1FFF));
            else if (sel < 6) a = m_pfx + AW'($urandom_range(0, 32'h1FFF));
            else if (sel < 9) a = AW'($urandom_range(0, 32'h0004_FFFF));
            else              a = $urandom;
            if ($urandom_range(0, 40) == 0)
                mem_limit = AW'($urandom_range(32'h0001_0000, 32'h0004_0000));
            step(a < 32'h2000 ? "R3" :
                 (a >= m_pfx && a < m_pfx + 32'h2000) ? "R4" : "R5",
                 1'($urandom_range(0, 7) != 0), a,
                 1'($urandom), 1'($urandom),
                 1'($urandom_range(0, 30) == 0), AW'($urandom_range(0, 32'h0003_FFFF)),
                 1'($urandom_range(0, 10) == 0), IW'($urandom), KW'($urandom));
        end
        for (int i = 0; i < PAGES; i += 7) readkey("R10", IW'(i));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule